// File: doc/BRIEF.md
# Seconds Prescaler with Periodic Wakeup Timer

This block turns a low-speed kernel clock, nominally 32.768 kHz or about 32 kHz, into a one-second tick. Two programmable dividers in series produce the tick. The first is a 7-bit asynchronous stage. The second is a 15-bit synchronous stage that counts the pulses of the first. With the asynchronous stage at 127, software sets the synchronous stage to 255 for a 32768 Hz source, or to 249 for a 32000 Hz source, and the cascade then gives exactly 1 Hz.

A 16-bit wakeup counter counts down on each second tick. When it expires it sets a sticky wakeup flag and reloads itself, so the wakeup repeats at a fixed interval. The flag stays set until software clears it. The interrupt line is the flag gated by an interrupt-enable bit.

Software reaches the block through a simple write port with three word addresses:
- Address 0 holds the control bits.
- Address 1 holds the two divider values.
- Address 2 holds the wakeup reload value.

Top module: `rtc_wake_timer`

## Requirements
- R1: After reset the block is disabled, the interrupt enable is 0 and the flag is 0. The divider fields reset to 127 (asynchronous) and 255 (synchronous), and the reload value resets to 0. All outputs are low.
- R2: Let A be the asynchronous value and S the synchronous value. Once enabled, sec_tick is a one-cycle pulse with a period of (A+1)*(S+1) cycles. The first pulse comes in the (A+1)*(S+1)-th cycle after the edge that enables the block.
- R3: A write to address 1 places the asynchronous value in bits [6:0] and the synchronous value in bits [30:16]. The write takes effect only while the block is disabled. While the block is enabled it is ignored, and the tick period does not change.
- R4: Let R be the reload value, held in bits [15:0] of address 2. wake_flag rises in the cycle after every (R+1)-th tick, counted from enable. With R = 0 it rises after every tick.
- R5: A write to address 0 with bit 2 set clears the flag. Apart from that write, the flag stays set. If the counter expires in the same cycle as the clear, the set wins.
- R6: wake_irq equals wake_flag AND the interrupt enable, which is bit 1 of address 0. The output is a level.
- R7: While the block runs, writing a reload value different from the current one restarts the wakeup countdown from the new value. A tick in that same cycle is not counted. Rewriting the value already held leaves the countdown undisturbed.
- R8: Bit 0 of address 0 enables the block. While it is 0, both dividers and the wakeup counter are held at their programmed values and no tick occurs. On re-enable, counting starts afresh. The flag keeps its value across a disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock (32.768 kHz class) |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 32 | Register write data |
| sec_tick | output | 1 | One-cycle pulse at the divided rate |
| wake_flag | output | 1 | Sticky wakeup flag |
| wake_irq | output | 1 | Level interrupt request |

## Verification
A wrong divider count changes the spacing of sec_tick, and this shows within one tick period of the fault. A wrong wakeup counter moves the rising edge of wake_flag by at least one tick from the position the model predicts. Clearing the flag between expiries exposes a missing set or a missing clear on the next expiry. Because the reference advances each cycle and is compared every cycle, a deviation is reported in the first cycle it reaches a port.

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer #(
  parameter int DW = 32,
  parameter int AW = 7,
  parameter int SW = 15,
  parameter int WW = 16,
  parameter int SYNC_LSB = 16,
  parameter logic [AW-1:0] ASYNC_INIT = 7'd127,
  parameter logic [SW-1:0] SYNC_INIT = 15'd255,
  parameter logic [WW-1:0] RELOAD_INIT = 16'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          sec_tick,
  output logic          wake_flag,
  output logic          wake_irq
);

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_PRESC = 2'd1;
  localparam logic [1:0] A_WAKE  = 2'd2;

  logic          en, ie, flag;
  logic [AW-1:0] adiv, acnt;
  logic [SW-1:0] sdiv, scnt;
  logic [WW-1:0] rld, wcnt;

  wire ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  wire presc_wr = wr_en && (wr_addr == A_PRESC);
  wire rld_wr   = wr_en && (wr_addr == A_WAKE);
  wire rld_chg  = rld_wr && (wr_data[WW-1:0] != rld);
  wire apre     = en && (acnt == '0);
  wire fire     = sec_tick && (wcnt == '0) && !rld_chg;

  assign sec_tick  = apre && (scnt == '0);
  assign wake_flag = flag;
  assign wake_irq  = flag && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ie   <= 1'b0;
      flag <= 1'b0;
      adiv <= ASYNC_INIT;
      sdiv <= SYNC_INIT;
      rld  <= RELOAD_INIT;
    end else begin
      if (ctrl_wr) begin
        en <= wr_data[0];
        ie <= wr_data[1];
      end
      if (presc_wr && !en) begin
        adiv <= wr_data[AW-1:0];
        sdiv <= wr_data[SYNC_LSB +: SW];
      end
      if (rld_chg) rld <= wr_data[WW-1:0];
      if (fire) flag <= 1'b1;
      else if (ctrl_wr && wr_data[2]) flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt <= ASYNC_INIT;
      scnt <= SYNC_INIT;
      wcnt <= RELOAD_INIT;
    end else if (!en) begin
      acnt <= adiv;
      scnt <= sdiv;
      wcnt <= rld;
    end else begin
      acnt <= apre ? adiv : acnt - 1'b1;
      if (apre) scnt <= (scnt == '0) ? sdiv : scnt - 1'b1;
      if (rld_chg) wcnt <= wr_data[WW-1:0];
      else if (sec_tick) wcnt <= (wcnt == '0) ? rld : wcnt - 1'b1;
    end
  end

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(ctrl_wr && wr_data[2]) |=> flag);

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !$past(flag) && $past(sec_tick) && ($past(wcnt) == '0) && !$past(rld_chg) |-> flag);

  // R3
  presc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && presc_wr |=> $stable(adiv) && $stable(sdiv));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !presc_wr && !rld_wr |=> (acnt == adiv) && (scnt == sdiv) && (wcnt == rld));

endmodule

// File: tb/sim_rtc_wake_timer.sv
module sim_rtc_wake_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic sec_tick, wake_flag, wake_irq;

  always #10 clk = ~clk;

  rtc_wake_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_tick(sec_tick), .wake_flag(wake_flag), .wake_irq(wake_irq)
  );

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R5";

  bit m_en, m_ie, m_flag;
  int m_a, m_s, m_r, phase, tk;

  function automatic bit exp_tick();
    int p = (m_a + 1) * (m_s + 1);
    return m_en && (phase % p == p - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_flag = 0; m_a = 127; m_s = 255; m_r = 0; phase = 0; tk = 0;
    end else begin
      bit tick, chg, fire, clr;
      tick = exp_tick();
      chg  = wr_en && wr_addr == 2 && int'(wr_data[15:0]) != m_r;
      clr  = wr_en && wr_addr == 0 && wr_data[2];
      fire = 0;
      if (m_en) phase++;
      if (tick && !chg) begin
        fire = (tk == m_r);
        tk = fire ? 0 : tk + 1;
      end
      if (chg) begin m_r = int'(wr_data[15:0]); tk = 0; end
      if (wr_en && wr_addr == 1 && !m_en) begin
        m_a = int'(wr_data[6:0]); m_s = int'(wr_data[30:16]);
      end
      if (wr_en && wr_addr == 0) begin
        if (!wr_data[0] || !m_en) begin phase = 0; if (!m_en) tk = 0; end
        if (!wr_data[0]) tk = 0;
        m_en = wr_data[0]; m_ie = wr_data[1];
      end
      if (fire) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && cyc > 3) begin
      chk("R2", "sec_tick", sec_tick, exp_tick());
      chk(cur_req, "wake_flag", wake_flag, m_flag);
      chk("R6", "wake_irq", wake_irq, m_flag && m_ie);
    end
    if (cyc > 190000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  initial begin
    run(2);
    rst_n = 1;
    run(2);
    chk("R1", "sec_tick", sec_tick, 1'b0);
    chk("R1", "wake_flag", wake_flag, 1'b0);
    chk("R1", "wake_irq", wake_irq, 1'b0);
    cur_req = "R4";
    wr(0, 32'h3);
    run(65600);
    cur_req = "R5";
    wr(0, 32'h6);
    run(5);
    cur_req = "R4";
    wr(1, (32'd4 << 16) | 32'd3);
    wr(2, 32'd2);
    wr(0, 32'h1);
    run(200);
    cur_req = "R5";
    wr(0, 32'h5);
    run(100);
    wr(0, 32'h3);
    cur_req = "R3";
    wr(1, (32'd1 << 16) | 32'd1);
    run(150);
    cur_req = "R7";
    run(7);
    wr(2, 32'd2);
    run(30);
    wr(2, 32'd5);
    run(300);
    cur_req = "R8";
    wr(0, 32'h2);
    run(50);
    wr(0, 32'h7);
    run(200);
    cur_req = "R5";
    wr(0, 32'h0);
    wr(1, 32'h0);
    wr(2, 32'h0);
    wr(0, 32'h3);
    run(10);
    wr(0, 32'h7);
    run(10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule